// File: doc/BRIEF.md
# Processor Debug Halt Controller

This block sits between a debug access port and a processor core and gives the debugger one small address window for stopping, stepping and inspecting the core. The window holds five registers. A control/status word enables debug, requests halt, arms single-step and masks interrupts. It also reports sticky reset and retire history, the core's halted state and whether a register transfer is ready. A cause word records why the core stopped. An exception-control word arms the reset and hard-fault catches and gates the watchpoint unit. A selector/data pair moves one core register at a time.

Halt is requested automatically by breakpoints, enabled watchpoints, external requests, armed vector catches and completed single steps. These reach the core only while debug is enabled. Core register traffic uses a one-cycle request to the core and a one-cycle completion pulse back. Writing the selector starts a transfer and drops the ready flag. The completion pulse sets the ready flag again and, for a read, loads the data register.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After synchronous reset, the cause (0x00), selector (0xC4), data (0xC8) and exception-control (0xCC) words read 0, and the control/status word (0xC0) reads 0x0001_0000 (ready set). `halt_req`, `step_en`, `mask_ints` and `xfer_req` are 0.
- R2: The registers decode at byte offsets 0x00, 0xC0, 0xC4, 0xC8 and 0xCC. Bits with no function read 0, and any other offset reads 0. Exception-control keeps only bits 0, 10 and 24. The data word keeps all 32 bits.
- R3: Control bit 0 enables debug and bit 1 is the halt request. `halt_req` is bit 1 AND bit 0, and it follows a write on the next clock edge. A write that sets both bits also sets cause bit 0.
- R4: While debug is enabled, a breakpoint pulse sets cause bit 1 and an external request sets cause bit 4, and each sets the halt bit. While debug is disabled, these events change neither the halt bit nor the cause word.
- R5: A watchpoint pulse sets cause bit 2 and the halt bit only when exception-control bit 24 is 1. Otherwise it is ignored.
- R6: Writing 1 to a cause bit clears it and writing 0 leaves it unchanged. When an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R7: Status bit 24 is set by any retire pulse and cleared by a read of 0xC0. A retire in the same cycle as that read leaves the bit set.
- R8: Status bit 25 is set every cycle the core is held in reset and cleared by a read of 0xC0. While reset persists, the bit reads 1 again on the next read.
- R9: Core reset clears the halt bit. When exception-control bit 0 is set and debug is enabled, the halt bit is instead 1 when reset releases, and cause bit 3 is set.
- R10: With exception-control bit 10 set and debug enabled, a hard-fault pulse sets the halt bit and cause bit 3. With bit 10 clear, the pulse is ignored.
- R11: With control bit 2 (step) set and debug enabled, a retire pulse sets the halt bit and cause bit 0. This lets the core run exactly one instruction after halt is released.
- R12: `mask_ints` equals control bit 3 AND enable, and `step_en` equals control bit 2 AND enable.
- R13: Writing the selector (register number in bits 4:0, write-not-read flag in bit 16) clears status bit 16. On the next cycle it drives a one-cycle `xfer_req` carrying the number, the direction and the data word. A `xfer_done` pulse during a transfer sets bit 16 and, for a read, loads `xfer_rdata` into the data word. A `xfer_done` pulse with no transfer open is ignored.
- R14: Status bit 17 mirrors the `core_halted` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears sticky status bits) |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ev_bkpt | input | 1 | Breakpoint match pulse |
| ev_watch | input | 1 | Watchpoint match pulse |
| ev_ext | input | 1 | External halt request pulse |
| ev_hardfault | input | 1 | Hard-fault entry pulse |
| core_in_reset | input | 1 | Core is held in reset |
| core_retire | input | 1 | Core retired an instruction |
| core_halted | input | 1 | Core is in debug halt |
| halt_req | output | 1 | Halt request to the core |
| step_en | output | 1 | Single-step armed |
| mask_ints | output | 1 | Mask maskable interrupts |
| xfer_req | output | 1 | One-cycle register transfer request |
| xfer_wr | output | 1 | Transfer direction, 1 = write to core |
| xfer_sel | output | 5 | Core register number |
| xfer_wdata | output | 32 | Value written to the core register |
| xfer_done | input | 1 | Transfer completion pulse |
| xfer_rdata | input | 32 | Value read from the core register |

## Verification
Two pairs of functions can land on the same clock edge. The first is a sticky-bit clear from a status read and a new retire event. The second is a write-1-to-clear of a cause bit and a fresh event on the same bit. The bench provokes each by raising the event strobe in the very cycle the read or clear strobe is active. It then judges the outcome from a later read, which must show the bit still set. The step-then-halt path is checked the same way: a retire arrives while halt is released and must bring `halt_req` back on the next edge.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned SEL_W  = 5;
    localparam int unsigned CAUSE_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'hC0;
    localparam logic [ADDR_W-1:0] OFS_SEL   = 8'hC4;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 8'hC8;
    localparam logic [ADDR_W-1:0] OFS_EXC   = 8'hCC;

    localparam int unsigned ST_RST_BIT    = 25;
    localparam int unsigned ST_RETIRE_BIT = 24;
    localparam int unsigned ST_HALTED_BIT = 17;
    localparam int unsigned ST_READY_BIT  = 16;
    localparam int unsigned SEL_WNR_BIT   = 16;
    localparam int unsigned EXC_VCRST_BIT = 0;
    localparam int unsigned EXC_VCHF_BIT  = 10;
    localparam int unsigned EXC_WPEN_BIT  = 24;

    // control bits 3..0, first member is the MSB
    typedef struct packed {
        logic maskints;
        logic step;
        logic halt;
        logic enable;
    } ctrl_t;

    // cause bits 4..0
    typedef struct packed {
        logic ext;
        logic vcatch;
        logic watch;
        logic bkpt;
        logic halted;
    } cause_t;

    typedef struct packed {
        logic wp_en;
        logic vc_hf;
        logic vc_rst;
    } exc_t;

    // write-1-to-clear with set priority
    function automatic cause_t cause_next(cause_t cur, logic [CAUSE_W-1:0] clr, cause_t set);
        return cause_t'((cur & ~clr) | set);
    endfunction

endpackage

// File: rtl/dbg_sticky.sv
module dbg_sticky #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_o[i] <= 1'b0;
            else
                q_o[i] <= set_i[i] | (q_o[i] & ~clr_i);
        end
    end
endmodule

// File: rtl/dbg_halt_core.sv
module dbg_halt_core
    import dbg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ctrl,
    input  logic               wr_cause,
    input  logic               wr_exc,
    input  logic [CAUSE_W-1:0] wbits,
    input  exc_t               exc_wbits,
    input  logic               ev_bkpt,
    input  logic               ev_watch,
    input  logic               ev_ext,
    input  logic               ev_hardfault,
    input  logic               core_in_reset,
    input  logic               core_retire,
    output ctrl_t              ctrl_q,
    output cause_t             cause_q,
    output exc_t               exc_q
);
    logic   en;
    logic   wp_hit, hf_hit, rst_hit, step_hit, dbg_halt_wr, halt_ev;
    cause_t cause_set;
    ctrl_t  ctrl_d;

    assign en          = ctrl_q.enable;
    assign wp_hit      = ev_watch & exc_q.wp_en;
    assign hf_hit      = ev_hardfault & exc_q.vc_hf;
    assign rst_hit     = core_in_reset & exc_q.vc_rst;
    assign step_hit    = ctrl_q.step & core_retire;
    assign dbg_halt_wr = wr_ctrl & wbits[1] & wbits[0];
    assign halt_ev     = en & (ev_bkpt | wp_hit | ev_ext | hf_hit | step_hit);

    always_comb begin
        cause_set.halted = dbg_halt_wr | (en & step_hit & ~core_in_reset);
        cause_set.bkpt   = en & ev_bkpt;
        cause_set.watch  = en & wp_hit;
        cause_set.vcatch = en & (hf_hit | rst_hit);
        cause_set.ext    = en & ev_ext;
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl)
            ctrl_d = ctrl_t'(wbits[3:0]);
        if (core_in_reset)
            ctrl_d.halt = en & exc_q.vc_rst;
        else if (halt_ev)
            ctrl_d.halt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            cause_q <= '0;
            exc_q   <= '0;
        end else begin
            ctrl_q  <= ctrl_d;
            cause_q <= cause_next(cause_q, wr_cause ? wbits : '0, cause_set);
            if (wr_exc)
                exc_q <= exc_wbits;
        end
    end
endmodule

// File: rtl/dbg_xfer.sv
module dbg_xfer
    import dbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] xfer_rdata,
    output logic [SEL_W-1:0]  sel_q,
    output logic              wnr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              ready_q,
    output logic              busy_q,
    output logic              req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            wnr_q   <= 1'b0;
            data_q  <= '0;
            ready_q <= 1'b1;
            busy_q  <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (wr_data)
                data_q <= wdata;
            if (wr_sel) begin
                sel_q   <= wdata[SEL_W-1:0];
                wnr_q   <= wdata[SEL_WNR_BIT];
                busy_q  <= 1'b1;
                ready_q <= 1'b0;
                req_q   <= 1'b1;
            end else if (busy_q && xfer_done) begin
                busy_q  <= 1'b0;
                ready_q <= 1'b1;
                if (!wnr_q)
                    data_q <= xfer_rdata;
            end
        end
    end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_bkpt,
    input  logic              ev_watch,
    input  logic              ev_ext,
    input  logic              ev_hardfault,
    input  logic              core_in_reset,
    input  logic              core_retire,
    input  logic              core_halted,
    output logic              halt_req,
    output logic              step_en,
    output logic              mask_ints,
    output logic              xfer_req,
    output logic              xfer_wr,
    output logic [SEL_W-1:0]  xfer_sel,
    output logic [DATA_W-1:0] xfer_wdata,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] xfer_rdata
);
    logic   wr_ctrl, wr_cause, wr_exc, wr_sel, wr_data, rd_ctrl;
    ctrl_t  ctrl_q;
    cause_t cause_q;
    exc_t   exc_q, exc_w;
    logic [1:0]        sticky_q;
    logic [SEL_W-1:0]  sel_q;
    logic              wnr_q, ready_q, busy_q, dbg_en;
    logic [DATA_W-1:0] data_q;

    assign wr_ctrl  = bus_wr & (bus_addr == OFS_CTRL);
    assign wr_cause = bus_wr & (bus_addr == OFS_CAUSE);
    assign wr_exc   = bus_wr & (bus_addr == OFS_EXC);
    assign wr_sel   = bus_wr & (bus_addr == OFS_SEL);
    assign wr_data  = bus_wr & (bus_addr == OFS_DATA);
    assign rd_ctrl  = bus_rd & (bus_addr == OFS_CTRL);

    assign exc_w = '{wp_en:  bus_wdata[EXC_WPEN_BIT],
                     vc_hf:  bus_wdata[EXC_VCHF_BIT],
                     vc_rst: bus_wdata[EXC_VCRST_BIT]};

    dbg_halt_core u_core (
        .clk          (clk),
        .rst          (rst),
        .wr_ctrl      (wr_ctrl),
        .wr_cause     (wr_cause),
        .wr_exc       (wr_exc),
        .wbits        (bus_wdata[CAUSE_W-1:0]),
        .exc_wbits    (exc_w),
        .ev_bkpt      (ev_bkpt),
        .ev_watch     (ev_watch),
        .ev_ext       (ev_ext),
        .ev_hardfault (ev_hardfault),
        .core_in_reset(core_in_reset),
        .core_retire  (core_retire),
        .ctrl_q       (ctrl_q),
        .cause_q      (cause_q),
        .exc_q        (exc_q)
    );

    // bit 1: core reset seen, bit 0: retire seen
    dbg_sticky #(.W(2)) u_sticky (
        .clk  (clk),
        .rst  (rst),
        .set_i({core_in_reset, core_retire}),
        .clr_i(rd_ctrl),
        .q_o  (sticky_q)
    );

    dbg_xfer u_xfer (
        .clk       (clk),
        .rst       (rst),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .wdata     (bus_wdata),
        .xfer_done (xfer_done),
        .xfer_rdata(xfer_rdata),
        .sel_q     (sel_q),
        .wnr_q     (wnr_q),
        .data_q    (data_q),
        .ready_q   (ready_q),
        .busy_q    (busy_q),
        .req_q     (xfer_req)
    );

    assign dbg_en     = ctrl_q.enable;
    assign halt_req   = ctrl_q.halt & dbg_en;
    assign step_en    = ctrl_q.step & dbg_en;
    assign mask_ints  = ctrl_q.maskints & dbg_en;
    assign xfer_wr    = wnr_q;
    assign xfer_sel   = sel_q;
    assign xfer_wdata = data_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CAUSE: bus_rdata[CAUSE_W-1:0] = cause_q;
            OFS_CTRL: begin
                bus_rdata[ST_RST_BIT]    = sticky_q[1];
                bus_rdata[ST_RETIRE_BIT] = sticky_q[0];
                bus_rdata[ST_HALTED_BIT] = core_halted;
                bus_rdata[ST_READY_BIT]  = ready_q;
                bus_rdata[3:0]           = ctrl_q;
            end
            OFS_SEL: begin
                bus_rdata[SEL_WNR_BIT] = wnr_q;
                bus_rdata[SEL_W-1:0]   = sel_q;
            end
            OFS_DATA: bus_rdata = data_q;
            OFS_EXC: begin
                bus_rdata[EXC_WPEN_BIT]  = exc_q.wp_en;
                bus_rdata[EXC_VCHF_BIT]  = exc_q.vc_hf;
                bus_rdata[EXC_VCRST_BIT] = exc_q.vc_rst;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ev_bkpt,
    input logic core_in_reset,
    input logic core_retire,
    input logic halt_req,
    input logic dbg_en,
    input logic wr_ctrl,
    input logic vc_rst,
    input logic retire_st,
    input logic xfer_req,
    input logic xfer_done,
    input logic wr_sel,
    input logic ready_q,
    input logic busy_q
);
    // R4
    bkpt_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_bkpt && dbg_en && !core_in_reset && !wr_ctrl) |=> halt_req);

    // R9
    core_rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (core_in_reset && !vc_rst) |=> !halt_req);

    // R7
    retire_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        core_retire |=> retire_st);

    // R13
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !wr_sel) |=> !xfer_req);

    // R13
    req_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> !ready_q);

    // R13
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && busy_q && !wr_sel) |=> ready_q);
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_bkpt      (ev_bkpt),
    .core_in_reset(core_in_reset),
    .core_retire  (core_retire),
    .halt_req     (halt_req),
    .dbg_en       (dbg_en),
    .wr_ctrl      (wr_ctrl),
    .vc_rst       (exc_q.vc_rst),
    .retire_st    (sticky_q[0]),
    .xfer_req     (xfer_req),
    .xfer_done    (xfer_done),
    .wr_sel       (wr_sel),
    .ready_q      (ready_q),
    .busy_q       (busy_q)
);

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        ev_bkpt = 0, ev_watch = 0, ev_ext = 0, ev_hardfault = 0;
    logic        core_in_reset = 0, core_retire = 0, core_halted = 0;
    logic        halt_req, step_en, mask_ints, xfer_req, xfer_wr;
    logic [4:0]  xfer_sel;
    logic [31:0] xfer_wdata;
    logic        xfer_done = 0;
    logic [31:0] xfer_rdata = 0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    dbg_halt_ctrl dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1;
        @(negedge clk);
        sig = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 halt_req", {31'b0, halt_req}, 0);
        chk("R1 step/mask", {30'b0, step_en, mask_ints}, 0);
        chk("R1 xfer_req", {31'b0, xfer_req}, 0);
        rd(8'hC0, v); chk("R1 status", v, 32'h0001_0000);
        rd(8'h00, v); chk("R1 cause", v, 0);
        rd(8'hC4, v); chk("R1 sel", v, 0);
        rd(8'hC8, v); chk("R1 data", v, 0);
        rd(8'hCC, v); chk("R1 exc", v, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(8'hC8, 32'hA5A5_5A5A);
        rd(8'hC8, v); chk("R2 data rw", v, 32'hA5A5_5A5A);
        wr(8'hCC, 32'hFFFF_FFFF);
        rd(8'hCC, v); chk("R2 exc bits", v, 32'h0100_0401);
        rd(8'h10, v); chk("R2 unmapped", v, 0);
        wr(8'hCC, 0);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        wr(8'hC0, 32'h2);
        chk("R3 halt without enable", {31'b0, halt_req}, 0);
        rd(8'h00, v); chk("R3 no cause w/o enable", v, 0);
        wr(8'hC0, 32'h3);
        chk("R3 halt_req", {31'b0, halt_req}, 1);
        rd(8'h00, v); chk("R3 cause bit0", v, 32'h1);
        wr(8'h00, 32'h1F);
        rd(8'h00, v); chk("R6 w1c all", v, 0);
        wr(8'hC0, 32'h1);
        chk("R3 release", {31'b0, halt_req}, 0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        pulse(ev_bkpt);
        chk("R4 bkpt halts", {31'b0, halt_req}, 1);
        wr(8'hC0, 32'h1);
        pulse(ev_ext);
        chk("R4 ext halts", {31'b0, halt_req}, 1);
        rd(8'h00, v); chk("R4 cause bkpt+ext", v, 32'h12);
        wr(8'h00, 32'h02);
        rd(8'h00, v); chk("R6 partial clear", v, 32'h10);
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h10; ev_ext = 1;
        @(negedge clk);
        bus_wr = 0; ev_ext = 0;
        rd(8'h00, v); chk("R6 set beats clear", v, 32'h10);
        wr(8'h00, 32'h1F);
        wr(8'hC0, 32'h1);
        pulse(ev_watch);
        chk("R5 watch ignored halt", {31'b0, halt_req}, 0);
        rd(8'h00, v); chk("R5 watch ignored cause", v, 0);
        wr(8'hCC, 32'h0100_0000);
        pulse(ev_watch);
        chk("R5 watch halts", {31'b0, halt_req}, 1);
        rd(8'h00, v); chk("R5 watch cause", v, 32'h04);
        wr(8'h00, 32'h1F);
        wr(8'hC0, 32'h0);
        pulse(ev_bkpt);
        rd(8'h00, v); chk("R4 disabled cause", v, 0);
        wr(8'hC0, 32'h1);
        chk("R4 disabled no halt", {31'b0, halt_req}, 0);
    endtask

    task automatic t_hardfault();
        logic [31:0] v;
        wr(8'hCC, 32'h400);
        pulse(ev_hardfault);
        chk("R10 hard fault halts", {31'b0, halt_req}, 1);
        rd(8'h00, v); chk("R10 vcatch cause", v, 32'h08);
        wr(8'h00, 32'h1F);
        wr(8'hC0, 32'h1);
        wr(8'hCC, 32'h0);
        pulse(ev_hardfault);
        chk("R10 unarmed ignored", {31'b0, halt_req}, 0);
        rd(8'h00, v); chk("R10 unarmed cause", v, 0);
    endtask

    task automatic t_mask_step();
        logic [31:0] v;
        wr(8'hC0, 32'h8);
        chk("R12 mask needs enable", {31'b0, mask_ints}, 0);
        wr(8'hC0, 32'h9);
        chk("R12 mask", {31'b0, mask_ints}, 1);
        wr(8'hC0, 32'h3);
        wr(8'h00, 32'h1F);
        wr(8'hC0, 32'h5);
        chk("R12 step_en", {31'b0, step_en}, 1);
        chk("R11 released", {31'b0, halt_req}, 0);
        pulse(core_retire);
        chk("R11 re-halt after one", {31'b0, halt_req}, 1);
        rd(8'h00, v); chk("R11 cause bit0", v, 32'h1);
        wr(8'h00, 32'h1F);
        wr(8'hC0, 32'h1);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        rd(8'hC0, v);
        rd(8'hC0, v); chk("R7 cleared by read", v & 32'h0300_0000, 0);
        pulse(core_retire);
        rd(8'hC0, v); chk("R7 retire set", v & 32'h0100_0000, 32'h0100_0000);
        rd(8'hC0, v); chk("R7 retire cleared", v & 32'h0100_0000, 0);
        @(negedge clk);
        bus_rd = 1; bus_addr = 8'hC0; core_retire = 1;
        @(negedge clk);
        bus_rd = 0; core_retire = 0;
        rd(8'hC0, v); chk("R7 retire beats read", v & 32'h0100_0000, 32'h0100_0000);
        pulse(core_in_reset);
        rd(8'hC0, v); chk("R8 reset seen", v & 32'h0200_0000, 32'h0200_0000);
        rd(8'hC0, v); chk("R8 reset cleared", v & 32'h0200_0000, 0);
        @(negedge clk); core_in_reset = 1;
        rd(8'hC0, v);
        rd(8'hC0, v); chk("R8 held reset rereads 1", v & 32'h0200_0000, 32'h0200_0000);
        @(negedge clk); core_in_reset = 0;
        rd(8'hC0, v);
        core_halted = 1;
        rd(8'hC0, v); chk("R14 halted mirror", v & 32'h0002_0000, 32'h0002_0000);
        core_halted = 0;
        rd(8'hC0, v); chk("R14 running", v & 32'h0002_0000, 0);
    endtask

    task automatic t_core_reset();
        logic [31:0] v;
        wr(8'hC0, 32'h3);
        pulse(core_in_reset);
        chk("R9 reset clears halt", {31'b0, halt_req}, 0);
        wr(8'h00, 32'h1F);
        wr(8'hCC, 32'h1);
        pulse(core_in_reset);
        chk("R9 reset catch halts", {31'b0, halt_req}, 1);
        rd(8'h00, v); chk("R9 vcatch cause", v, 32'h08);
        wr(8'h00, 32'h1F);
        wr(8'hCC, 32'h0);
        wr(8'hC0, 32'h1);
    endtask

    task automatic t_xfer();
        logic [31:0] v;
        wr(8'hC8, 32'h1234_5678);
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'hC4; bus_wdata = 32'h0001_0003;
        @(negedge clk);
        bus_wr = 0;
        chk("R13 req", {31'b0, xfer_req}, 1);
        chk("R13 dir write", {31'b0, xfer_wr}, 1);
        chk("R13 sel", {27'b0, xfer_sel}, 3);
        chk("R13 wdata", xfer_wdata, 32'h1234_5678);
        @(negedge clk);
        chk("R13 req one cycle", {31'b0, xfer_req}, 0);
        rd(8'hC0, v); chk("R13 ready low", v & 32'h0001_0000, 0);
        xfer_rdata = 32'h0000_DEAD;
        pulse(xfer_done);
        rd(8'hC0, v); chk("R13 ready after done", v & 32'h0001_0000, 32'h0001_0000);
        rd(8'hC8, v); chk("R13 write keeps data", v, 32'h1234_5678);
        wr(8'hC4, 32'h11);
        xfer_rdata = 32'hCAFE_F00D;
        pulse(xfer_done);
        rd(8'hC8, v); chk("R13 read loads data", v, 32'hCAFE_F00D);
        xfer_rdata = 32'h0;
        pulse(xfer_done);
        rd(8'hC8, v); chk("R13 stray done ignored", v, 32'hCAFE_F00D);
        rd(8'hC4, v); chk("R13 sel readback", v, 32'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_map();
        wr(8'hC0, 32'h1);
        t_halt();
        t_events();
        t_hardfault();
        t_mask_step();
        t_sticky();
        t_core_reset();
        t_xfer();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule